// File: doc/BRIEF.md
# Frame-Synchronous Layer Mixer Control Register File

This block is the register file that sits beside a multi-layer video mixer. Software writes a control word with a run bit. For every foreground layer it also writes a horizontal offset, a vertical offset and an activity mode. Writes go through a plain register bus and may arrive at any moment. The mixer datapath never sees these live values directly. It works from shadow copies, which are refreshed only when the datapath pulses a frame-start strobe. A frame that has begun therefore keeps one consistent set of settings until it ends.

The same strobe drives the run sequencing. At each frame boundary the block looks at the run bit. If the bit is set, it loads the shadows and marks the mixer as running. If the bit is clear, it marks the mixer as stopped and keeps the shadows as they were. So clearing the run bit halts the mixer at the next boundary, not at once. A status register reports whether the mixer is running.

For each layer the block decodes the shadowed mode into two plain enables. One says the layer is shown. The other says the layer's input stream is pulled. Both are held low while the mixer is stopped. The number of foreground layers is a parameter from 1 to 4. A register map position is decoded only when it exists for the chosen layer count.

Top module: `mixctl_top`

## Requirements
- R1: After reset, the run bit, the running flag, every live and shadow layer field, `bus_rdata`, `lay_show` and `lay_pull` are all 0.
- R2: Address 0 is the control register. A write stores `bus_wdata[0]` as the run bit. A read returns the run bit in bit 0 and 0 in bits 15..1.
- R3: Layer n (n from 1) owns three registers. Address 2+3(n-1) holds the X offset, address 3+3(n-1) holds the Y offset, and address 4+3(n-1) holds the mode. X and Y read back all 16 bits. The mode register stores `bus_wdata[1:0]` and reads back with bits 15..2 at 0.
- R4: A read presents its data on `bus_rdata` on the clock edge that samples `bus_rd` high. `bus_rdata` then holds that value until the next read.
- R5: The layer outputs (`lay_xoff`, `lay_yoff`, `lay_show`, `lay_pull`) change only on an edge that samples `frame_start` high. A register write made between strobes has no effect on them until the next strobe.
- R6: An edge that samples `frame_start` high while the run bit is 1 sets `mix_running` to 1. The same edge copies every layer's live X, Y and mode into its shadow. The copy uses the values held before that edge.
- R7: An edge that samples `frame_start` high while the run bit is 0 clears `mix_running` and leaves all shadows unchanged. Clearing the run bit has no effect on `mix_running` until such an edge.
- R8: Address 1 is the status register. A read returns `mix_running` in bit 0 and 0 in bits 15..1. Writes to it are ignored.
- R9: Layer n's shadow mode is decoded as follows. Mode 1 gives show=1 and pull=1. Mode 2 gives show=0 and pull=1. Modes 0 and 3 give show=0 and pull=0. Bit n-1 of `lay_show` and `lay_pull` carries the result, and both buses are 0 while `mix_running` is 0.
- R10: Addresses at or above 2+3·LAYERS read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe, one register per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| frame_start | input | 1 | One-cycle pulse from the datapath at each frame boundary |
| mix_running | output | 1 | Mixer is processing frames |
| lay_xoff | output | 16·LAYERS | Shadow X offsets, layer n at bits [16n-1:16(n-1)] |
| lay_yoff | output | 16·LAYERS | Shadow Y offsets, same packing |
| lay_show | output | LAYERS | Layer is composited |
| lay_pull | output | LAYERS | Layer input stream is consumed |

## Verification
The bench builds the block with LAYERS=3 and ADDR_W=4. This leaves addresses 11 to 15 outside the map while still reachable on the bus, so the read-as-zero and write-ignored rule can be tested. With three layers in place, one bench run covers the shown, drained, off and reserved modes side by side. The run bit is toggled across several strobes so that both the stop hold and the restart reload are observed at the frame boundary.

// File: rtl/mixctl_pkg.sv
package mixctl_pkg;
  localparam int REG_W     = 16;
  localparam int MODE_W    = 2;
  localparam int HDR_REGS  = 2;
  localparam int LAYER_REG = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF   = 2'd0,
    MODE_SHOW  = 2'd1,
    MODE_DRAIN = 2'd2,
    MODE_RSVD  = 2'd3
  } lay_mode_e;

  typedef struct packed {
    logic [REG_W-1:0]  xoff;
    logic [REG_W-1:0]  yoff;
    logic [MODE_W-1:0] mode;
  } lay_cfg_t;

  typedef enum logic {SEQ_STOP = 1'b0, SEQ_RUN = 1'b1} seq_state_e;

  // {show, pull} for a mode value
  function automatic logic [1:0] mode_path(input logic [MODE_W-1:0] m);
    case (lay_mode_e'(m))
      MODE_SHOW:  mode_path = 2'b11;
      MODE_DRAIN: mode_path = 2'b01;
      default:    mode_path = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/mixctl_decode.sv
module mixctl_decode #(
  parameter int NUM_REGS = 14,
  parameter int ADDR_W   = 4
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  output logic [NUM_REGS-1:0] sel,
  output logic [NUM_REGS-1:0] we
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel[i] = (32'(addr) == i);
    assign we[i]  = sel[i] & wr;
  end
endmodule

// File: rtl/mixctl_layer.sv
module mixctl_layer
  import mixctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_x,
  input  logic             we_y,
  input  logic             we_m,
  input  logic [REG_W-1:0] wdata,
  input  logic             load,
  output lay_cfg_t         live,
  output lay_cfg_t         shadow
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
    end else begin
      if (we_x) live.xoff <= wdata;
      if (we_y) live.yoff <= wdata;
      if (we_m) live.mode <= wdata[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    shadow <= '0;
    else if (load) shadow <= live;
  end
endmodule

// File: rtl/mixctl_seq.sv
module mixctl_seq
  import mixctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic run_bit,
  output logic load,
  output logic running
);
  seq_state_e state_q;

  assign load    = frame_start & run_bit;
  assign running = (state_q == SEQ_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n)           state_q <= SEQ_STOP;
    else if (frame_start) state_q <= run_bit ? SEQ_RUN : SEQ_STOP;
  end
endmodule

// File: rtl/mixctl_top.sv
module mixctl_top
  import mixctl_pkg::*;
#(
  parameter int LAYERS = 4,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [15:0]             bus_wdata,
  input  logic                    bus_rd,
  output logic [15:0]             bus_rdata,
  input  logic                    frame_start,
  output logic                    mix_running,
  output logic [16*LAYERS-1:0]    lay_xoff,
  output logic [16*LAYERS-1:0]    lay_yoff,
  output logic [LAYERS-1:0]       lay_show,
  output logic [LAYERS-1:0]       lay_pull
);
  localparam int NUM_REGS = HDR_REGS + LAYER_REG * LAYERS;

  logic [NUM_REGS-1:0] reg_sel, reg_we;
  logic                run_q;
  logic                shadow_load;
  logic [REG_W-1:0]    rd_terms [NUM_REGS];
  logic [REG_W-1:0]    rd_val;
  lay_cfg_t            live_cfg   [LAYERS];
  lay_cfg_t            shadow_cfg [LAYERS];

  mixctl_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .sel  (reg_sel),
    .we   (reg_we)
  );

  mixctl_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .run_bit     (run_q),
    .load        (shadow_load),
    .running     (mix_running)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= 1'b0;
    else if (reg_we[0]) run_q <= bus_wdata[0];
  end

  assign rd_terms[0] = {{(REG_W-1){1'b0}}, run_q};
  assign rd_terms[1] = {{(REG_W-1){1'b0}}, mix_running};

  for (genvar l = 0; l < LAYERS; l++) begin : g_lay
    localparam int BASE = HDR_REGS + LAYER_REG * l;
    logic [1:0] path;

    mixctl_layer u_lay (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_x   (reg_we[BASE]),
      .we_y   (reg_we[BASE+1]),
      .we_m   (reg_we[BASE+2]),
      .wdata  (bus_wdata),
      .load   (shadow_load),
      .live   (live_cfg[l]),
      .shadow (shadow_cfg[l])
    );

    assign rd_terms[BASE]   = live_cfg[l].xoff;
    assign rd_terms[BASE+1] = live_cfg[l].yoff;
    assign rd_terms[BASE+2] = {{(REG_W-MODE_W){1'b0}}, live_cfg[l].mode};

    assign path = mode_path(shadow_cfg[l].mode);
    assign lay_xoff[16*l +: 16] = shadow_cfg[l].xoff;
    assign lay_yoff[16*l +: 16] = shadow_cfg[l].yoff;
    assign lay_show[l] = path[1] & mix_running;
    assign lay_pull[l] = path[0] & mix_running;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (reg_sel[i]) rd_val = rd_val | rd_terms[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/mixctl_chk.sv
module mixctl_chk #(
  parameter int LAYERS = 4,
  parameter int ADDR_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_rd,
  input logic [15:0]          bus_rdata,
  input logic                 frame_start,
  input logic                 run_bit,
  input logic                 mix_running,
  input logic [16*LAYERS-1:0] lay_xoff,
  input logic [16*LAYERS-1:0] lay_yoff,
  input logic [LAYERS-1:0]    lay_show,
  input logic [LAYERS-1:0]    lay_pull
);
  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(lay_xoff) && $stable(lay_yoff) &&
                      $stable(lay_show) && $stable(lay_pull)));

  // R6
  run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && run_bit) |=> mix_running);

  // R7
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !run_bit) |=> (!mix_running && $stable(lay_xoff) && $stable(lay_yoff)));

  // R7
  run_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mix_running));

  // R8
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(1)) |=> (bus_rdata == {15'd0, $past(mix_running)}));

  // R9
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mix_running |-> (lay_show == '0 && lay_pull == '0));

  // R9
  show_needs_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lay_show & ~lay_pull) == '0);
endmodule

bind mixctl_top mixctl_chk #(.LAYERS(LAYERS), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .frame_start (frame_start),
  .run_bit     (run_q),
  .mix_running (mix_running),
  .lay_xoff    (lay_xoff),
  .lay_yoff    (lay_yoff),
  .lay_show    (lay_show),
  .lay_pull    (lay_pull)
);

// File: tb/mixctl_top_tb.sv
module mixctl_top_tb;
  localparam int LAYERS = 3;
  localparam int ADDR_W = 4;
  localparam int NVEC   = 22;

  // {is_read, addr, wdata, expected}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b0, 4'd2,  16'h1234, 16'h0000},
    {1'b0, 4'd3,  16'h00AB, 16'h0000},
    {1'b0, 4'd4,  16'hFFFD, 16'h0000},
    {1'b0, 4'd5,  16'h8000, 16'h0000},
    {1'b0, 4'd6,  16'h0007, 16'h0000},
    {1'b0, 4'd7,  16'h0002, 16'h0000},
    {1'b0, 4'd0,  16'hFFFF, 16'h0000},
    {1'b1, 4'd0,  16'h0000, 16'h0001},
    {1'b1, 4'd2,  16'h0000, 16'h1234},
    {1'b1, 4'd3,  16'h0000, 16'h00AB},
    {1'b1, 4'd4,  16'h0000, 16'h0001},
    {1'b1, 4'd5,  16'h0000, 16'h8000},
    {1'b1, 4'd6,  16'h0000, 16'h0007},
    {1'b1, 4'd7,  16'h0000, 16'h0002},
    {1'b1, 4'd1,  16'h0000, 16'h0000},
    {1'b0, 4'd1,  16'hFFFF, 16'h0000},
    {1'b1, 4'd1,  16'h0000, 16'h0000},
    {1'b0, 4'd13, 16'h5A5A, 16'h0000},
    {1'b1, 4'd13, 16'h0000, 16'h0000},
    {1'b1, 4'd15, 16'h0000, 16'h0000},
    {1'b1, 4'd2,  16'h0000, 16'h1234},
    {1'b1, 4'd0,  16'h0000, 16'h0001}
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [ADDR_W-1:0]    bus_addr = '0;
  logic                 bus_wr = 1'b0;
  logic [15:0]          bus_wdata = '0;
  logic                 bus_rd = 1'b0;
  logic [15:0]          bus_rdata;
  logic                 frame_start = 1'b0;
  logic                 mix_running;
  logic [16*LAYERS-1:0] lay_xoff, lay_yoff;
  logic [LAYERS-1:0]    lay_show, lay_pull;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mixctl_top #(.LAYERS(LAYERS), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .frame_start(frame_start), .mix_running(mix_running),
    .lay_xoff(lay_xoff), .lay_yoff(lay_yoff),
    .lay_show(lay_show), .lay_pull(lay_pull)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  function automatic string tag_for(input int a);
    if (a == 0) return "R2";
    if (a == 1) return "R8";
    if (a < 2 + 3 * LAYERS) return "R3";
    return "R10";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [15:0] rv;
    repeat (3) @(negedge clk);
    // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", bus_rdata, 0);
    check("R1 running", mix_running, 0);
    check("R1 show/pull", {lay_show, lay_pull}, 0);
    check("R1 xoff", lay_xoff, 0);
    bus_read(2, rv);
    check("R1 live x", rv, 0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][36]) begin
        bus_read(int'(VEC[i][35:32]), rv);
        check(tag_for(int'(VEC[i][35:32])), rv, VEC[i][15:0]);
      end else begin
        bus_write(int'(VEC[i][35:32]), VEC[i][31:16]);
      end
    end

    // R5: writes so far not yet visible
    check("R5 pre-frame x", lay_xoff, 0);
    check("R5 pre-frame y", lay_yoff, 0);

    // R6 start, R9 decode
    frame();
    check("R6 running", mix_running, 1);
    check("R6 xoff", lay_xoff, {16'h0000, 16'h8000, 16'h1234});
    check("R6 yoff", lay_yoff, {16'h0000, 16'h0007, 16'h00AB});
    check("R9 show", lay_show, 3'b001);
    check("R9 pull", lay_pull, 3'b011);
    bus_read(1, rv);
    check("R8 status running", rv, 1);

    // R5 mid-frame write
    bus_write(2, 16'h5555);
    repeat (2) @(negedge clk);
    check("R5 mid-frame hold", lay_xoff[15:0], 16'h1234);
    bus_write(10, 16'h0003);
    frame();
    check("R5 next frame x", lay_xoff[15:0], 16'h5555);
    check("R9 reserved mode", {lay_show[2], lay_pull[2]}, 2'b00);

    // R7 stop at boundary
    bus_write(0, 16'h0000);
    repeat (2) @(negedge clk);
    check("R7 still running", mix_running, 1);
    bus_write(2, 16'h0F0F);
    frame();
    check("R7 stopped", mix_running, 0);
    check("R7 shadow held", lay_xoff[15:0], 16'h5555);
    check("R9 gated when stopped", {lay_show, lay_pull}, 0);
    bus_read(1, rv);
    check("R8 status stopped", rv, 0);

    // R6 restart reloads
    bus_write(0, 16'h0001);
    frame();
    check("R6 restart", mix_running, 1);
    check("R6 reload x", lay_xoff[15:0], 16'h0F0F);

    // R4 rdata holds between reads
    bus_read(3, rv);
    @(negedge clk);
    bus_addr = ADDR_W'(0);
    repeat (3) @(negedge clk);
    check("R4 rdata hold", bus_rdata, 16'h00AB);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset running", mix_running, 0);
    check("R1 reset shadows", {lay_xoff, lay_yoff}, 0);
    bus_read(0, rv);
    check("R1 reset run bit", rv, 0);

    finish_run();
  end
endmodule